// File: doc/BRIEF.md
# Indirect Load Store Unit

This unit carries out the register-indirect memory instructions of an accumulator processor. When a start strobe arrives with a load or store opcode, it forms a byte address from a base held in an address register plus an 8-bit offset taken from the instruction. It then performs one 32-bit word, 16-bit halfword or 8-bit byte access against a byte-addressed synchronous data memory that has per-byte write enables.

The offset counts in units of the access size, so it is scaled before it is added to the base. Every access takes the same two phases:

- The first phase presents the address and, for a load, issues the read.
- The second phase consumes the read word or, for a store, drives the write with its byte enables.

A one-cycle done pulse follows. On a load, the selected byte or halfword is sign-extended to 32 bits. Instruction decode, the ALU and the register file sit outside this block.

Top module: `ind_lsu`

## Requirements
- R1: A start is accepted only while idle and only for opcode bits [7:3] = 01100 (load) or 01110 (store) with size bits [1:0] of 00 (word), 01 (byte) or 10 (halfword). Bit 2 has no effect. Any other opcode, including size 11, produces no read, no write and no done.
- R2: The address on mem_addr is base + (zero-extended offset shifted left by 2 for word, 1 for halfword, 0 for byte), taken modulo 2^ADDR_W. It holds that value through both phases of the access.
- R3: The cycle after acceptance is phase one, with mem_rd high for loads and low for stores. The next cycle is phase two, with mem_rd low and mem_wr high only for stores.
- R4: A word store drives mem_be = 1111 and mem_wdata equal to the store data.
- R5: A byte store drives exactly one enable, mem_be[k] with k = address bits [1:0]. Lane k is bits [8k+7:8k]. The low store-data byte is replicated into all four lanes.
- R6: A halfword store drives mem_be = 0011 when address bit 1 is 0 and 1100 when it is 1. Address bit 0 is ignored. The low store-data halfword is replicated into both halves.
- R7: A word load returns the full 32-bit read word on ld_data.
- R8: A byte load returns lane (address bits [1:0]) of the read word, and a halfword load returns the half chosen by address bit 1. Both are sign-extended to 32 bits.
- R9: done is high for exactly one cycle, the cycle after phase two, for loads and stores alike. From that cycle ld_data holds the load result until the next load completes, and it resets to 0.
- R10: A start while phase one or phase two is in progress is ignored. The access under way keeps its address and kind.
- R11: A store scales its offset by its own size, so the same offset gives different addresses for word, halfword and byte stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an access |
| opcode | input | 8 | Instruction opcode byte |
| offset | input | OFF_W | Unsigned offset in units of the access size |
| base | input | ADDR_W | Base byte address from the address register |
| st_data | input | 32 | Store data from the accumulator |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_rd |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_be | output | 4 | Byte enables for the write |
| mem_rd | output | 1 | Read request in phase one |
| mem_wr | output | 1 | Write request in phase two |
| ld_data | output | 32 | Load result, sign-extended for sub-word sizes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with ADDR_W = 16 and OFF_W = 8. With a 16-bit address, a base near 0xFFFF plus a scaled offset wraps past the top of the space, which brings the modulo rule of address formation within a short test. The full 8-bit offset range, scaled by four, still lands inside the bench's 512-word memory. As a result, every byte lane, both halfword positions and the largest offset are reached with real memory contents that have mixed sign bits.

// File: rtl/ind_lsu_pkg.sv
// Shared types for the indirect load/store unit.
// Assumes a 32-bit data path split into four 8-bit lanes, little-endian.
package ind_lsu_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    // Access size as carried in opcode bits [1:0]
    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/ind_ea_calc.sv
// Effective address generator.
// Scales the unsigned offset by the access size and adds it to the base.
// Assumes ADDR_W is at least OFF_W; the sum wraps modulo 2^ADDR_W.
module ind_ea_calc
    import ind_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] off_scaled;

    assign off_ext = ADDR_W'(offset);

    // Shift the offset into bytes according to the access size
    always_comb begin
        case (size)
            SZ_WORD: off_scaled = off_ext << 2;
            SZ_HALF: off_scaled = off_ext << 1;
            default: off_scaled = off_ext;
        endcase
    end

    assign ea = base + off_scaled;
endmodule

// File: rtl/ind_lane_map.sv
// Lane steering between the accumulator and a 32-bit memory word.
// Stores: replicates data into lanes and raises the enables of the addressed lanes.
// Loads: picks the addressed byte or halfword and sign-extends it.
// Assumes little-endian lanes; halfword placement uses address bit 1 only.
module ind_lane_map
    import ind_lsu_pkg::*;
(
    input  acc_size_e          size,
    input  logic [1:0]         addr_lo,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [DATA_W-1:0]  rd_word,
    output logic [DATA_W-1:0]  wr_word,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  ld_word
);
    logic [LANE_W-1:0]   lane_byte [LANES];
    logic [LANE_W-1:0]   pick_byte;
    logic [2*LANE_W-1:0] pick_half;

    // Per-lane enable and byte split of the read word
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_byte[k] = rd_word[k*LANE_W +: LANE_W];
        always_comb begin
            case (size)
                SZ_WORD: be[k] = 1'b1;
                SZ_BYTE: be[k] = (addr_lo == 2'(k));
                SZ_HALF: be[k] = (addr_lo[1] == 1'(k / 2));
                default: be[k] = 1'b0;
            endcase
        end
    end

    // Replicate store data across lanes according to size
    always_comb begin
        case (size)
            SZ_BYTE: wr_word = {LANES{st_data[LANE_W-1:0]}};
            SZ_HALF: wr_word = {2{st_data[2*LANE_W-1:0]}};
            default: wr_word = st_data;
        endcase
    end

    assign pick_byte = lane_byte[addr_lo];
    assign pick_half = addr_lo[1] ? rd_word[DATA_W-1 -: 2*LANE_W] : rd_word[2*LANE_W-1:0];

    // Select and sign-extend the load result
    always_comb begin
        case (size)
            SZ_BYTE: ld_word = {{(DATA_W-LANE_W){pick_byte[LANE_W-1]}}, pick_byte};
            SZ_HALF: ld_word = {{(DATA_W-2*LANE_W){pick_half[2*LANE_W-1]}}, pick_half};
            default: ld_word = rd_word;
        endcase
    end
endmodule

// File: rtl/ind_seq.sv
// Two-phase access sequencer.
// Accepts a legal indirect load/store opcode while idle, latches the address,
// kind, size and store data, then runs phase one, phase two and a done pulse.
// Assumes the memory returns read data one cycle after the read request.
module ind_seq
    import ind_lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] ea_d,
    input  logic [DATA_W-1:0] st_data,
    output logic              ph1,
    output logic              ph2,
    output logic              is_store,
    output acc_size_e         size_q,
    output logic [ADDR_W-1:0] ea_q,
    output logic [DATA_W-1:0] wd_q,
    output logic              done
);
    typedef enum logic [1:0] { S_IDLE, S_PH1, S_PH2 } seq_state_e;

    seq_state_e state;
    logic       legal;
    logic       accept;

    // Legal: 011x0 in bits [7:3] and a defined size in bits [1:0]
    assign legal  = (opcode[7:5] == 3'b011) && !opcode[3] && (opcode[1:0] != 2'b11);
    assign accept = start && legal && (state == S_IDLE);

    // State advance, operand capture and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            done     <= 1'b0;
            is_store <= 1'b0;
            size_q   <= SZ_WORD;
            ea_q     <= '0;
            wd_q     <= '0;
        end else begin
            done <= (state == S_PH2);
            case (state)
                S_IDLE: if (accept) begin
                    state    <= S_PH1;
                    is_store <= opcode[4];
                    size_q   <= acc_size_e'(opcode[1:0]);
                    ea_q     <= ea_d;
                    wd_q     <= st_data;
                end
                S_PH1:   state <= S_PH2;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign ph1 = (state == S_PH1);
    assign ph2 = (state == S_PH2);
endmodule

// File: rtl/ind_lsu.sv
// Indirect load/store unit top.
// Forms the scaled effective address, sequences a read phase and a write
// phase against a synchronous byte-enabled memory, and returns a
// sign-extended load result with a one-cycle done pulse.
// Assumes mem_rdata is valid in the cycle after mem_rd.
module ind_lsu
    import ind_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] base,
    input  logic [31:0]       st_data,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       ld_data,
    output logic              done
);
    logic [ADDR_W-1:0] ea_d;
    logic [ADDR_W-1:0] ea_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] ld_word;
    logic [LANES-1:0]  lane_be;
    logic              ph1;
    logic              ph2;
    logic              is_store;
    acc_size_e         size_q;
    logic [DATA_W-1:0] ld_q;

    ind_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
        .base   (base),
        .offset (offset),
        .size   (acc_size_e'(opcode[1:0])),
        .ea     (ea_d)
    );

    ind_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opcode   (opcode),
        .ea_d     (ea_d),
        .st_data  (st_data),
        .ph1      (ph1),
        .ph2      (ph2),
        .is_store (is_store),
        .size_q   (size_q),
        .ea_q     (ea_q),
        .wd_q     (wd_q),
        .done     (done)
    );

    ind_lane_map u_lane (
        .size    (size_q),
        .addr_lo (ea_q[1:0]),
        .st_data (wd_q),
        .rd_word (mem_rdata),
        .wr_word (wr_word),
        .be      (lane_be),
        .ld_word (ld_word)
    );

    // Capture the load result when the read word arrives in phase two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else if (ph2 && !is_store) begin
            ld_q <= ld_word;
        end
    end

    assign mem_addr  = ea_q;
    assign mem_rd    = ph1 && !is_store;
    assign mem_wr    = ph2 && is_store;
    assign mem_wdata = wr_word;
    assign mem_be    = mem_wr ? lane_be : '0;
    assign ld_data   = ld_q;

    // Done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Done only follows phase two
    assert_done_after_ph2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ph2));
    // A write only comes in the cycle after phase one
    assert_wr_after_ph1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(ph1) && !mem_rd));
    // No second read can start while an access is in flight
    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // Address is held across both phases
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph2 |-> $stable(mem_addr));
    // Byte store hits exactly one lane
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && size_q == SZ_BYTE) |-> ($countones(mem_be) == 1));
    // Halfword store hits one aligned half
    assert_half_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && size_q == SZ_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));
endmodule

// File: tb/tb_ind_lsu.sv
module tb_ind_lsu;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [OW-1:0] offset = '0;
    logic [AW-1:0] base = '0;
    logic [31:0]   st_data = '0;
    logic [31:0]   mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_rd, mem_wr, done;
    logic [31:0]   ld_data;

    int total = 0;
    int bad = 0;

    logic [31:0] mem    [512];
    logic [31:0] shadow [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_lsu #(.ADDR_W(AW), .OFF_W(OW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .offset(offset),
        .base(base), .st_data(st_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ld_data(ld_data), .done(done)
    );

    function automatic logic [31:0] pat(int i);
        return {8'(i*37+145), 8'(i*11+2), 8'(i*5+200), 8'(i*3+9)};
    endfunction

    // Synchronous byte-enabled memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
            if (mem_wr)
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem[mem_addr[10:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_ea(logic [7:0] op, logic [OW-1:0] off, logic [AW-1:0] b);
        int sh;
        sh = (op[1:0] == 2'b00) ? 2 : (op[1:0] == 2'b10) ? 1 : 0;
        return AW'(b + (AW'(off) << sh));
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] a);
        if (sz == 2'b00) return 4'b1111;
        if (sz == 2'b01) return 4'(1 << a);
        return a[1] ? 4'b1100 : 4'b0011;
    endfunction

    function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'b01) return {4{d[7:0]}};
        if (sz == 2'b10) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_ld(logic [1:0] sz, logic [1:0] a, logic [31:0] w);
        logic [7:0]  b8;
        logic [15:0] h16;
        b8  = w[a*8 +: 8];
        h16 = a[1] ? w[31:16] : w[15:0];
        if (sz == 2'b01) return {{24{b8[7]}}, b8};
        if (sz == 2'b10) return {{16{h16[15]}}, h16};
        return w;
    endfunction

    // Full access with checks in every phase
    task automatic do_access(input logic [7:0] op, input logic [OW-1:0] off,
                             input logic [AW-1:0] b, input logic [31:0] d, input string req);
        logic [AW-1:0] ea;
        logic [8:0]    idx;
        logic [31:0]   neww;
        logic [3:0]    be;
        bit            st;
        ea  = exp_ea(op, off, b);
        idx = ea[10:2];
        st  = op[4];
        be  = exp_be(op[1:0], ea[1:0]);
        @(negedge clk);
        start = 1'b1; opcode = op; offset = off; base = b; st_data = d;
        @(negedge clk);
        start = 1'b0;
        chk(mem_addr == ea, req, "phase1 addr", 32'(mem_addr), 32'(ea));
        chk(mem_rd == !st, "R3", "phase1 rd", 32'(mem_rd), 32'(!st));
        chk(mem_wr == 1'b0, "R3", "phase1 wr", 32'(mem_wr), 0);
        @(negedge clk);
        chk(mem_addr == ea, "R2", "phase2 addr", 32'(mem_addr), 32'(ea));
        chk(mem_wr == st && !mem_rd, "R3", "phase2 wr", 32'(mem_wr), 32'(st));
        if (st) begin
            chk(mem_be == be, req, "be", 32'(mem_be), 32'(be));
            chk(mem_wdata == exp_wd(op[1:0], d), req, "wdata", mem_wdata, exp_wd(op[1:0], d));
        end
        @(negedge clk);
        chk(done == 1'b1, "R9", "done", 32'(done), 1);
        if (st) begin
            neww = shadow[idx];
            for (int k = 0; k < 4; k++) if (be[k]) neww[k*8 +: 8] = exp_wd(op[1:0], d)[k*8 +: 8];
            shadow[idx] = neww;
            chk(mem[idx] == neww, req, "stored word", mem[idx], neww);
        end else begin
            chk(ld_data == exp_ld(op[1:0], ea[1:0], shadow[idx]), req, "load result",
                ld_data, exp_ld(op[1:0], ea[1:0], shadow[idx]));
        end
        @(negedge clk);
        chk(done == 1'b0, "R9", "done pulse width", 32'(done), 0);
    endtask

    task automatic t_reset();
        chk(done == 0 && mem_rd == 0 && mem_wr == 0, "R9", "reset ctrl",
            {29'd0, done, mem_rd, mem_wr}, 0);
        chk(ld_data == 0, "R9", "reset ld_data", ld_data, 0);
        chk(mem_be == 0, "R3", "reset be", 32'(mem_be), 0);
    endtask

    task automatic t_word();
        do_access(8'h70, 8'd5, 16'h0100, 32'hCAFE_1234, "R4");
        do_access(8'h60, 8'd5, 16'h0100, 32'h0, "R7");
        do_access(8'h60, 8'd255, 16'h0000, 32'h0, "R7");
    endtask

    task automatic t_byte();
        for (int k = 0; k < 4; k++) begin
            do_access(8'h71, 8'(16 + k), 16'h0040, 32'h0000_00F0 + 32'(k), "R5");
            do_access(8'h61, 8'(16 + k), 16'h0040, 32'h0, "R8");
        end
        do_access(8'h61, 8'd2, 16'h0201, 32'h0, "R8");
    endtask

    task automatic t_half();
        do_access(8'h72, 8'd3, 16'h0080, 32'h0000_8A5C, "R6");
        do_access(8'h72, 8'd3, 16'h0081, 32'h0000_1357, "R6");
        do_access(8'h62, 8'd3, 16'h0080, 32'h0, "R8");
        do_access(8'h62, 8'd2, 16'h0081, 32'h0, "R8");
        do_access(8'h62, 8'd9, 16'h0300, 32'h0, "R8");
    endtask

    task automatic t_scale();
        do_access(8'h70, 8'd6, 16'h0400, 32'h1111_2222, "R11");
        do_access(8'h72, 8'd6, 16'h0400, 32'h0000_3344, "R11");
        do_access(8'h71, 8'd6, 16'h0400, 32'h0000_0055, "R11");
        do_access(8'h60, 8'd6, 16'h0400, 32'h0, "R11");
    endtask

    task automatic t_bit2();
        do_access(8'h64, 8'd7, 16'h0020, 32'h0, "R1");
        do_access(8'h75, 8'd1, 16'h0023, 32'h0000_00A7, "R1");
    endtask

    task automatic t_wrap();
        do_access(8'h70, 8'd2, 16'hFFFC, 32'hDEAD_BEEF, "R2");
        do_access(8'h60, 8'd1, 16'h0000, 32'h0, "R2");
    endtask

    task automatic t_illegal();
        logic [7:0] ops [4] = '{8'h63, 8'h73, 8'h20, 8'h68};
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            start = 1'b1; opcode = ops[j]; offset = 8'd1; base = 16'h0010; st_data = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 3; c++) begin
                chk(!mem_rd && !mem_wr && !done, "R1", "illegal op activity",
                    {29'd0, mem_rd, mem_wr, done}, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_busy();
        logic [AW-1:0] ea;
        ea = exp_ea(8'h60, 8'd3, 16'h0500);
        @(negedge clk);
        start = 1'b1; opcode = 8'h60; offset = 8'd3; base = 16'h0500;
        @(negedge clk);
        opcode = 8'h71; offset = 8'd9; base = 16'h0600; st_data = 32'h77;
        chk(mem_rd && mem_addr == ea, "R10", "phase1 of first", 32'(mem_addr), 32'(ea));
        @(negedge clk);
        chk(!mem_wr && mem_addr == ea, "R10", "phase2 ignores start", 32'(mem_addr), 32'(ea));
        start = 1'b0;
        @(negedge clk);
        chk(done && ld_data == shadow[ea[10:2]], "R10", "first load result",
            ld_data, shadow[ea[10:2]]);
        @(negedge clk);
        chk(!done && !mem_rd && !mem_wr, "R10", "no second access",
            {29'd0, done, mem_rd, mem_wr}, 0);
        chk(ld_data == shadow[ea[10:2]], "R9", "ld_data held", ld_data, shadow[ea[10:2]]);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_byte();
        t_half();
        t_scale();
        t_bit2();
        t_wrap();
        t_illegal();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule